// File: doc/BRIEF.md
# Table Base Register Sanitizer

This block holds two 64-bit table base registers that software programs through a simple register port: slot 0 describes the device table and slot 1 describes the collection table. Six further slots share the same decode window; they read as zero and drop writes. Each accepted write is merged into the addressed register, either as a full 64-bit word or as one 32-bit half. The merged value is then forced into a legal form before it is stored, so a read always returns a value the rest of the unit can trust.

Several fields cannot be written. The entry-size and type fields always carry the table's own constants. The page-size field is pinned to the 64 KiB code. The indirect bit is cleared for the collection table, and a reserved shareability code is replaced. While the unit's enable input is high the registers cannot be written at all. When a write leaves a table marked invalid, a one-cycle flush pulse for that table tells neighbouring logic to drop any state it cached from it.

Top module: `tbs_sanitizer`

## Requirements
- R1: After synchronous reset, slot 0 reads 0x3900_0000_0000_0600 and slot 1 reads 0x3C00_0000_0000_0600. These values are inner cacheability 7 in [61:59], outer cacheability 0 in [55:53], shareability 1 in [11:10], page size 2 in [9:8], entry size 0, and type 1 or 4 in [58:56].
- R2: `addr_i` is a 32-bit word address. `addr_i[3:1]` selects the slot and `addr_i[0]` selects the upper half. Only slots 0 and 1 hold state. Slots 2 to 7 read as zero, and writes to them change no register and raise no flush.
- R3: After any accepted write, bits [52:48] read 7 (8-byte entries). Bits [58:56] read 1 in slot 0 and 4 in slot 1, whatever was written.
- R4: After any accepted write, bit 62 of slot 1 reads 0. Bit 62 of slot 0 keeps the written value.
- R5: After any accepted write, bits [9:8] read 2.
- R6: A shareability code of 3 in bits [11:10] is stored as 1, and codes 0 to 2 are kept. Bits [63], [61:59], [55:53], [47:12] and [7:0] keep the written values.
- R7: While `enable_i` is high, writes change no register and raise no flush.
- R8: When `wide_i` is high, a write replaces all 64 bits and ignores `addr_i[0]`. When `wide_i` is low, `wdata_i[31:0]` replaces only the half chosen by `addr_i[0]`. Sanitizing is applied to the merged 64-bit value.
- R9: Reads are combinational from `addr_i` and `wide_i`. When `wide_i` is high, `rdata_o` returns the full register. When `wide_i` is low, it returns the selected half, zero-extended.
- R10: An accepted write to slot i whose merged value has bit 63 clear sets `flush_o[i]` for exactly the one cycle after the write edge. In every other case `flush_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Unit enabled; blocks all register writes |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| addr_i | input | 4 | Word address: [3:1] slot, [0] upper half |
| wdata_i | input | 64 | Write data (only [31:0] for 32-bit writes) |
| rdata_o | output | 64 | Read data for the addressed slot and width |
| flush_o | output | 2 | One-cycle invalidation pulse per table |

## Verification
Read data depends only on the current address, width and stored state, so the bench samples it about 1 ns after changing the address, with no clock edge in between. A write lands at the first rising edge after it is driven. The flush pulse and the new register value are both due in the half-cycle after that edge, and the bench samples them at the next falling edge. At the falling edge one cycle later, the flush must already be low again. Random word and half writes, with the enable high about a quarter of the time, are mixed with directed cases for the reserved shareability code, the indirect bit, the empty slots and the reset values.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    localparam int REG_W      = 64;
    localparam int HALF_W     = REG_W / 2;
    localparam int NUM_TABLES = 2;
    localparam int SLOT_W     = 3;
    localparam int NUM_SLOTS  = 1 << SLOT_W;
    localparam int WADDR_W    = SLOT_W + 1;

    localparam logic [1:0] PAGE_64K      = 2'd2;
    localparam logic [1:0] SHARE_INNER   = 2'd1;
    localparam logic [1:0] SHARE_RSVD    = 2'd3;
    localparam logic [2:0] CACHE_RAWB    = 3'd7;
    localparam logic [2:0] CACHE_AS_INNER = 3'd0;

    typedef enum logic [2:0] {
        KIND_NONE       = 3'd0,
        KIND_DEVICE     = 3'd1,
        KIND_COLLECTION = 3'd4
    } table_kind_e;

    typedef struct packed {
        logic             valid;
        logic             wide;
        logic             upper;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic logic [REG_W-1:0] merge_write(logic [REG_W-1:0] old_v, wr_req_t req);
        logic [REG_W-1:0] v;
        v = old_v;
        if (req.wide)       v = req.data;
        else if (req.upper) v[REG_W-1:HALF_W] = req.data[HALF_W-1:0];
        else                v[HALF_W-1:0]     = req.data[HALF_W-1:0];
        return v;
    endfunction

    function automatic logic [REG_W-1:0] legalize(logic [REG_W-1:0] raw, table_kind_e kind,
                                                  int entry_bytes, bit drop_indirect);
        logic [REG_W-1:0] v;
        v        = raw;
        v[52:48] = 5'(entry_bytes - 1);
        v[58:56] = kind;
        if (drop_indirect) v[62] = 1'b0;
        v[9:8]   = PAGE_64K;
        if (v[11:10] == SHARE_RSVD) v[11:10] = SHARE_INNER;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] reset_image(table_kind_e kind);
        logic [REG_W-1:0] v;
        v        = '0;
        v[61:59] = CACHE_RAWB;
        v[55:53] = CACHE_AS_INNER;
        v[58:56] = kind;
        v[11:10] = SHARE_INNER;
        v[9:8]   = PAGE_64K;
        return v;
    endfunction

endpackage

// File: rtl/tbs_decode.sv
module tbs_decode
    import tbs_pkg::*;
(
    input  logic [WADDR_W-1:0]   waddr,
    output logic [NUM_SLOTS-1:0] slot_sel,
    output logic                 upper
);
    logic [SLOT_W-1:0] slot;

    assign slot  = waddr[WADDR_W-1:1];
    assign upper = waddr[0];

    always_comb begin
        slot_sel       = '0;
        slot_sel[slot] = 1'b1;
    end

    always_comb begin
        assert ($onehot(slot_sel)) else $error("a_r2_single_slot");
    end
endmodule

// File: rtl/tbs_table_reg.sv
module tbs_table_reg
    import tbs_pkg::*;
#(
    parameter table_kind_e KIND          = KIND_DEVICE,
    parameter int          ENTRY_BYTES   = 8,
    parameter bit          DROP_INDIRECT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    output logic [REG_W-1:0] q,
    output logic             flush
);
    logic [REG_W-1:0] next_v;

    assign next_v = legalize(merge_write(q, req), KIND, ENTRY_BYTES, DROP_INDIRECT);

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= reset_image(KIND);
            flush <= 1'b0;
        end else begin
            flush <= req.valid && !next_v[REG_W-1];
            if (req.valid) q <= next_v;
        end
    end

    // R3: read-only fields hold their constants after a write
    a_r3_fixed_fields: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> (q[58:56] == KIND) && (q[52:48] == 5'(ENTRY_BYTES - 1)));
    // R5: page size is always the 64 KiB code
    a_r5_page_size: assert property (@(posedge clk) disable iff (rst)
        q[9:8] == PAGE_64K);
    // R6: the reserved shareability code is never stored
    a_r6_share_legal: assert property (@(posedge clk) disable iff (rst)
        q[11:10] != SHARE_RSVD);
    // R10: a flush only follows a write that cleared the valid bit
    a_r10_flush_cause: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!q[REG_W-1] && $past(req.valid)));
    a_r10_flush_single: assert property (@(posedge clk) disable iff (rst)
        !req.valid |=> !flush);

    generate
        if (DROP_INDIRECT) begin : g_ind
            // R4: indirect bit held clear on this table
            a_r4_no_indirect: assert property (@(posedge clk) disable iff (rst)
                !q[62]);
        end
    endgenerate
endmodule

// File: rtl/tbs_sanitizer.sv
module tbs_sanitizer
    import tbs_pkg::*;
#(
    parameter int DEV_ENTRY_BYTES  = 8,
    parameter int COLL_ENTRY_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable_i,
    input  logic                  wr_en_i,
    input  logic                  wide_i,
    input  logic [WADDR_W-1:0]    addr_i,
    input  logic [REG_W-1:0]      wdata_i,
    output logic [REG_W-1:0]      rdata_o,
    output logic [NUM_TABLES-1:0] flush_o
);
    logic [NUM_SLOTS-1:0] slot_sel;
    logic                 upper;
    logic [REG_W-1:0]     table_q [NUM_TABLES];
    logic [REG_W-1:0]     full_v;

    tbs_decode u_decode (
        .waddr    (addr_i),
        .slot_sel (slot_sel),
        .upper    (upper)
    );

    generate
        for (genvar i = 0; i < NUM_TABLES; i++) begin : g_tbl
            localparam bit          IS_COLL = (i == 1);
            localparam table_kind_e KIND_I  = IS_COLL ? KIND_COLLECTION : KIND_DEVICE;
            localparam int          EB_I    = IS_COLL ? COLL_ENTRY_BYTES : DEV_ENTRY_BYTES;
            wr_req_t req;

            assign req.valid = wr_en_i && !enable_i && slot_sel[i];
            assign req.wide  = wide_i;
            assign req.upper = upper;
            assign req.data  = wdata_i;

            tbs_table_reg #(
                .KIND          (KIND_I),
                .ENTRY_BYTES   (EB_I),
                .DROP_INDIRECT (IS_COLL)
            ) u_reg (
                .clk   (clk),
                .rst   (rst),
                .req   (req),
                .q     (table_q[i]),
                .flush (flush_o[i])
            );
        end
    endgenerate

    always_comb begin
        full_v = '0;
        for (int i = 0; i < NUM_TABLES; i++)
            if (slot_sel[i]) full_v = table_q[i];
    end

    always_comb begin
        if (wide_i)     rdata_o = full_v;
        else if (upper) rdata_o = {{HALF_W{1'b0}}, full_v[REG_W-1:HALF_W]};
        else            rdata_o = {{HALF_W{1'b0}}, full_v[HALF_W-1:0]};
    end

    // R7: enable freezes both registers
    a_r7_enable_freeze: assert property (@(posedge clk) disable iff (rst)
        enable_i |=> ($stable(table_q[0]) && $stable(table_q[1]) && flush_o == '0));
    // R2: writes to stateless slots touch nothing
    a_r2_empty_slot_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i[WADDR_W-1:1] >= SLOT_W'(NUM_TABLES)) |=>
        ($stable(table_q[0]) && $stable(table_q[1]) && flush_o == '0));
    // R10: at most one table flushes per cycle
    a_r10_flush_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flush_o));
endmodule

// File: tb/tbs_sanitizer_tb.sv
module tbs_sanitizer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        enable_i;
    logic        wr_en_i;
    logic        wide_i;
    logic [3:0]  addr_i;
    logic [63:0] wdata_i;
    logic [63:0] rdata_o;
    logic [1:0]  flush_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [63:0] model [2];

    always #2.5 clk = ~clk;

    tbs_sanitizer u_dut (
        .clk(clk), .rst(rst), .enable_i(enable_i), .wr_en_i(wr_en_i),
        .wide_i(wide_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .flush_o(flush_o)
    );

    function automatic logic [63:0] m_fix(logic [63:0] v, int t);
        v[52:48] = 5'd7;
        v[58:56] = (t == 0) ? 3'd1 : 3'd4;
        if (t == 1) v[62] = 1'b0;
        v[9:8] = 2'd2;
        if (v[11:10] == 2'd3) v[11:10] = 2'd1;
        return v;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(int slot, bit wide, bit up, string req);
        logic [63:0] full, e;
        addr_i = {3'(slot), up};
        wide_i = wide;
        #1;
        full = (slot < 2) ? model[slot] : 64'd0;
        e = wide ? full : (up ? {32'd0, full[63:32]} : {32'd0, full[31:0]});
        check(req, rdata_o, e);
    endtask

    task automatic do_write(int slot, bit wide, bit up, logic [63:0] d, bit en, string req);
        logic [1:0]  ef;
        logic [63:0] m;
        @(negedge clk);
        check("R10 pulse ended", {62'd0, flush_o}, 64'd0);
        enable_i = en; wr_en_i = 1'b1; wide_i = wide;
        addr_i = {3'(slot), up}; wdata_i = d;
        ef = 2'b00;
        if (!en && slot < 2) begin
            m = model[slot];
            if (wide) m = d;
            else if (up) m[63:32] = d[31:0];
            else m[31:0] = d[31:0];
            m = m_fix(m, slot);
            model[slot] = m;
            if (!m[63]) ef[slot] = 1'b1;
        end
        @(negedge clk);
        wr_en_i = 1'b0; enable_i = 1'b0;
        check({req, " R10 flush"}, {62'd0, flush_o}, {62'd0, ef});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; enable_i = 0; wr_en_i = 0; wide_i = 1; addr_i = 0; wdata_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        model[0] = 64'h3900_0000_0000_0600;
        model[1] = 64'h3C00_0000_0000_0600;
        check("R1 reset flush", {62'd0, flush_o}, 64'd0);
        do_read(0, 1, 0, "R1 reset slot0");
        do_read(1, 1, 0, "R1 reset slot1");

        // R3 R4 R5 R6: all-ones word
        do_write(0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3");
        do_read(0, 1, 0, "R3 R4 R6 slot0 all ones");
        do_write(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4");
        do_read(1, 1, 0, "R4 slot1 indirect clear");
        check("R4 bit62 slot1", {63'd0, rdata_o[62]}, 64'd0);
        check("R6 share 3->1", {62'd0, rdata_o[11:10]}, 64'd1);
        // R5 R10: zero word (valid clear) -> flush
        do_write(0, 1, 0, 64'd0, 0, "R5");
        do_read(0, 1, 0, "R5 page size forced");
        check("R5 bits 9:8", {62'd0, rdata_o[9:8]}, 64'd2);
        // R7: enabled write ignored
        do_write(0, 1, 0, 64'h8000_0000_0000_0000, 1, "R7");
        do_read(0, 1, 0, "R7 frozen");
        // R2: empty slots
        for (int s = 2; s < 8; s++) begin
            do_write(s, 1, 0, 64'h1234_5678_9ABC_DEF0, 0, "R2");
            do_read(s, 1, 0, "R2 empty slot reads zero");
            do_read(s, 0, 1, "R2 empty slot half zero");
        end
        do_read(0, 1, 0, "R2 slot0 untouched");
        do_read(1, 1, 0, "R2 slot1 untouched");
        // R8: half writes
        do_write(1, 0, 1, 64'hAAAA_AAAA_8000_0000, 0, "R8 upper");
        do_read(1, 0, 1, "R8 R9 upper half");
        do_write(1, 0, 0, 64'h5555_5555_0000_0F00, 0, "R8 lower");
        do_read(1, 0, 0, "R8 R9 lower half");
        do_read(1, 1, 0, "R8 merged full");

        for (int k = 0; k < 600; k++) begin
            int s;
            bit w, u, e;
            s = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 2);
            w = $urandom % 2;
            u = $urandom % 2;
            e = ($urandom % 4) == 0;
            do_write(s, w, u, {$urandom, $urandom}, e, "R8 random");
            do_read(0, 1, 0, "R3 R6 random slot0");
            do_read(1, 1, 0, "R4 R6 random slot1");
            do_read(int'($urandom % 8), 0, $urandom % 2, "R9 random half");
        end

        @(negedge clk);
        check("R10 final idle", {62'd0, flush_o}, 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule